// File: doc/BRIEF.md
# DRAM Refresh Request Scheduler

This block sets the refresh cadence for a synchronous DRAM controller. A free-running interval counter adds one owed auto refresh to a small backlog every `REF_INTERVAL` clocks; the parameter is sized from the clock frequency so that 4096 refreshes fit in every 64 ms window (about one per 15.6 µs). Owed refreshes are offered to the command sequencer over a valid/ready request channel. The sequencer raises `req_ready` only when it is idle with every bank precharged, and it drives the matching refresh command on the DRAM pins in the cycle after the grant.

The same channel carries a self-refresh entry request. The scheduler raises it when the system asks for self refresh and no auto refresh is owed. Once that request is granted, the block drives the clock-enable pin low in the same cycle as the sequencer's entry command. When the system withdraws its request, clock enable goes high again and `cmd_hold` keeps the sequencer on NOP/deselect for at least the refresh cycle time (`TRRC_CLK` clocks). After that the periodic cadence starts again from zero. Back-pressure rule: once `req_valid` is high it stays high, with `req_kind` unchanged, until a cycle in which `req_ready` is high. That cycle is the transfer.

Top module: `refresh_scheduler`

## Requirements
- R1: In reset and right after it, `req_valid` is 0, `cke` is 1, `backlog` is 0, `urgent` is 0 and `cmd_hold` is 0.
- R2: While not in self refresh, `backlog` rises by one every `REF_INTERVAL` clocks. The first increase comes `REF_INTERVAL` clocks after reset release, or after `cmd_hold` falls following a self-refresh exit.
- R3: While `backlog` is nonzero and no hold-off is running, the block raises `req_valid` with `req_kind` = 0 (auto refresh). Each transfer of an auto request lowers `backlog` by one.
- R4: A pending request keeps `req_valid` high and `req_kind` stable until it is transferred.
- R5: `backlog` never exceeds `MAX_OWED` (8 by default). Further intervals are dropped while it is full, and `urgent` is 1 exactly while `backlog` equals `MAX_OWED`.
- R6: A self-refresh entry request (`req_kind` = 1) is raised only while `sr_req` is high and `backlog` is 0, so owed auto refreshes drain first.
- R7: After an auto request is transferred, `req_valid` stays low for `TRRC_CLK` clocks.
- R8: In the cycle after a self-refresh request is transferred, `cke` is 0 and `backlog` is 0. `cke` stays 0 while `sr_req` remains high.
- R9: One clock after `sr_req` falls in self refresh, `cke` returns to 1. `cmd_hold` stays high for `TRRC_CLK` + 1 clocks from that point and then falls.
- R10: While `cmd_hold` is high, `req_valid` is 0. `cke` is 0 only while `cmd_hold` is high.
- R11: The interval counter is paused during self refresh and its exit hold-off, so `backlog` stays 0 however long that lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sr_req | input | 1 | Level request to be in self refresh |
| req_ready | input | 1 | Sequencer grant: idle, all banks precharged |
| req_valid | output | 1 | Refresh request offered |
| req_kind | output | 1 | 0 = auto refresh, 1 = self-refresh entry |
| cke | output | 1 | Clock-enable level for the DRAM |
| cmd_hold | output | 1 | Sequencer must issue only NOP/deselect |
| backlog | output | $clog2(MAX_OWED+1) | Number of owed auto refreshes |
| urgent | output | 1 | Backlog is at its limit |

## Verification
A miscounting interval counter moves the first `backlog` step away from clock `REF_INTERVAL`, which is visible within one interval. A lost saturation or clear shows as a `backlog` above the limit, or nonzero after entry, on the next clock. A wrong request register lets `req_kind` change under back-pressure, or lets a self entry overtake owed refreshes. The scoreboard sees that at the next transfer. A short hold-off counter releases `cmd_hold` or `req_valid` a clock early, and the bench samples exactly at that clock.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

  typedef enum logic {
    KIND_AUTO = 1'b0,
    KIND_SELF = 1'b1
  } req_kind_e;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_SELF = 2'd1,
    ST_EXIT = 2'd2
  } sched_state_e;

endpackage

// File: rtl/refsched_interval.sv
module refsched_interval #(
  parameter int REF_INTERVAL = 3120,
  localparam int CNT_W = $clog2(REF_INTERVAL)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  logic [CNT_W-1:0] cnt_q;
  logic             at_end;

  assign at_end = (cnt_q == CNT_W'(REF_INTERVAL - 1));
  assign tick   = en & at_end;

  always_ff @(posedge clk) begin
    if (!rst_n || !en || at_end) cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/refsched_backlog.sv
module refsched_backlog #(
  parameter int MAX_OWED = 8,
  localparam int OWE_W = $clog2(MAX_OWED + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  input  logic             clr,
  output logic [OWE_W-1:0] count,
  output logic             full
);
  logic [OWE_W-1:0] count_q;
  logic             empty;

  assign full  = (count_q == OWE_W'(MAX_OWED));
  assign empty = (count_q == '0);
  assign count = count_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      count_q <= '0;
    end else begin
      unique case ({inc, dec && !empty})
        2'b10:   if (!full) count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end
endmodule

// File: rtl/refsched_holdoff.sv
module refsched_holdoff #(
  parameter int TRRC_CLK = 14,
  localparam int HOLD_W = $clog2(TRRC_CLK + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  logic [HOLD_W-1:0] left_q;

  assign busy = (left_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)    left_q <= '0;
    else if (load) left_q <= HOLD_W'(TRRC_CLK);
    else if (busy) left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/refresh_scheduler.sv
module refresh_scheduler
  import refsched_pkg::*;
#(
  parameter int REF_INTERVAL = 3120,
  parameter int MAX_OWED     = 8,
  parameter int TRRC_CLK     = 14,
  localparam int OWE_W = $clog2(MAX_OWED + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sr_req,
  input  logic             req_ready,
  output logic             req_valid,
  output logic             req_kind,
  output logic             cke,
  output logic             cmd_hold,
  output logic [OWE_W-1:0] backlog,
  output logic             urgent
);
  sched_state_e state_q;
  req_kind_e    kind_q;
  logic         vld_q;
  logic         cke_q;

  logic xfer, xfer_auto, xfer_self;
  logic tick, hold_busy, hold_load;
  logic owed, can_offer, want_auto, want_self;
  logic [OWE_W-1:0] owed_cnt;

  assign xfer      = vld_q & req_ready;
  assign xfer_auto = xfer & (kind_q == KIND_AUTO);
  assign xfer_self = xfer & (kind_q == KIND_SELF);

  refsched_interval #(.REF_INTERVAL(REF_INTERVAL)) u_interval (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (state_q == ST_RUN),
    .tick  (tick)
  );

  refsched_backlog #(.MAX_OWED(MAX_OWED)) u_backlog (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (tick),
    .dec   (xfer_auto),
    .clr   (xfer_self),
    .count (owed_cnt),
    .full  (urgent)
  );

  assign hold_load = xfer_auto | ((state_q == ST_SELF) & ~sr_req);

  refsched_holdoff #(.TRRC_CLK(TRRC_CLK)) u_holdoff (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (hold_load),
    .busy  (hold_busy)
  );

  assign owed      = (owed_cnt != '0);
  assign can_offer = (state_q == ST_RUN) & ~hold_busy & ~vld_q;
  assign want_auto = owed;
  assign want_self = sr_req & ~owed;

  // request register: loads once, holds until transfer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      kind_q <= KIND_AUTO;
    end else if (xfer) begin
      vld_q  <= 1'b0;
    end else if (can_offer && (want_auto || want_self)) begin
      vld_q  <= 1'b1;
      kind_q <= want_auto ? KIND_AUTO : KIND_SELF;
    end
  end

  // self-refresh sequencing of clock enable
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      cke_q   <= 1'b1;
    end else begin
      unique case (state_q)
        ST_RUN:  if (xfer_self) begin
                   state_q <= ST_SELF;
                   cke_q   <= 1'b0;
                 end
        ST_SELF: if (!sr_req) begin
                   state_q <= ST_EXIT;
                   cke_q   <= 1'b1;
                 end
        ST_EXIT: if (!hold_busy) state_q <= ST_RUN;
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign req_valid = vld_q;
  assign req_kind  = kind_q;
  assign cke       = cke_q;
  assign cmd_hold  = (state_q != ST_RUN);
  assign backlog   = owed_cnt;
endmodule

// File: rtl/refresh_scheduler_chk.sv
module refresh_scheduler_chk #(
  parameter int MAX_OWED = 8,
  parameter int TRRC_CLK = 14,
  localparam int OWE_W  = $clog2(MAX_OWED + 1),
  localparam int HOLD_W = $clog2(TRRC_CLK + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             req_valid,
  input logic             req_kind,
  input logic             cke,
  input logic             cmd_hold,
  input logic [OWE_W-1:0] backlog
);
  logic [HOLD_W-1:0] gap_cnt;
  logic [HOLD_W-1:0] exit_cnt;
  logic              cke_d;
  logic              cke_rise;

  assign cke_rise = cke & ~cke_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_cnt  <= '0;
      exit_cnt <= '0;
      cke_d    <= 1'b1;
    end else begin
      cke_d <= cke;
      if (req_valid && req_ready && !req_kind) gap_cnt <= HOLD_W'(TRRC_CLK);
      else if (gap_cnt != '0)                  gap_cnt <= gap_cnt - 1'b1;
      if (cke_rise)                            exit_cnt <= HOLD_W'(TRRC_CLK);
      else if (exit_cnt != '0)                 exit_cnt <= exit_cnt - 1'b1;
    end
  end

  p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_kind));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    backlog <= OWE_W'(MAX_OWED));

  p_drain_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) && req_kind |-> $past(backlog) == '0);

  p_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    gap_cnt != '0 |-> !req_valid);

  p_enter_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_kind |=> !cke && backlog == '0);

  p_exit_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cke_rise || exit_cnt != '0 |-> cmd_hold);

  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_hold |-> !req_valid);

  p_cke_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> cmd_hold);

  p_paused_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_hold |-> backlog == '0);
endmodule

bind refresh_scheduler refresh_scheduler_chk #(
  .MAX_OWED (MAX_OWED),
  .TRRC_CLK (TRRC_CLK)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .req_valid (req_valid),
  .req_kind  (req_kind),
  .cke       (cke),
  .cmd_hold  (cmd_hold),
  .backlog   (backlog)
);

// File: tb/refresh_scheduler_tb.sv
module refresh_scheduler_tb;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int RI = 64;
  localparam int MO = 8;
  localparam int TR = 3;
  localparam int OW = $clog2(MO + 1);

  logic          clk = 1'b0;
  logic          rst_n, sr_req, req_ready;
  logic          req_valid, req_kind, cke, cmd_hold, urgent;
  logic [OW-1:0] backlog;

  int   n_chk  = 0;
  int   n_fail = 0;
  logic exp_q[$];

  always #2.5 clk = ~clk;

  refresh_scheduler #(.REF_INTERVAL(RI), .MAX_OWED(MO), .TRRC_CLK(TR)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .sr_req    (sr_req),
    .req_ready (req_ready),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .cke       (cke),
    .cmd_hold  (cmd_hold),
    .backlog   (backlog),
    .urgent    (urgent)
  );

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  // monitor: compare each transfer against the expected queue
  always @(negedge clk) begin
    #1;
    if (rst_n === 1'b1 && req_valid && req_ready) begin
      if (exp_q.size() == 0) begin
        chk("R6", "unexpected transfer", 1, 0);
      end else begin
        chk("R6", "transfer kind", int'(req_kind), int'(exp_q.pop_front()));
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    chk("R1", "watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; sr_req = 1'b0; req_ready = 1'b0;
    step(3);
    rst_n = 1'b1;
    chk("R1", "valid after reset", int'(req_valid), 0);
    chk("R1", "cke after reset", int'(cke), 1);
    chk("R1", "backlog after reset", int'(backlog), 0);
    chk("R1", "urgent after reset", int'(urgent), 0);
    chk("R1", "hold after reset", int'(cmd_hold), 0);

    step(RI - 1);
    chk("R2", "backlog before first interval", int'(backlog), 0);
    step(1);
    chk("R2", "backlog at first interval", int'(backlog), 1);
    step(1);
    chk("R3", "auto request valid", int'(req_valid), 1);
    chk("R3", "auto request kind", int'(req_kind), 0);

    step(511 - 65);
    chk("R5", "backlog one below limit", int'(backlog), MO - 1);
    chk("R5", "urgent below limit", int'(urgent), 0);
    step(1);
    chk("R5", "backlog at limit", int'(backlog), MO);
    chk("R5", "urgent at limit", int'(urgent), 1);
    step(68);
    chk("R5", "backlog saturated", int'(backlog), MO);
    chk("R4", "request held under back-pressure", int'(req_valid), 1);

    // drain with self refresh wanted: eight autos, then entry
    for (int i = 0; i < MO; i++) exp_q.push_back(1'b0);
    exp_q.push_back(1'b1);
    sr_req = 1'b1; req_ready = 1'b1;
    for (int i = 0; i < 80 && cke; i++) step(1);
    chk("R8", "cke after entry transfer", int'(cke), 0);
    chk("R8", "backlog cleared on entry", int'(backlog), 0);
    chk("R10", "hold in self refresh", int'(cmd_hold), 1);
    chk("R6", "queue drained in order", exp_q.size(), 0);
    req_ready = 1'b0;

    step(150);
    chk("R8", "cke stays low", int'(cke), 0);
    chk("R11", "backlog paused", int'(backlog), 0);
    chk("R10", "no request in self refresh", int'(req_valid), 0);

    sr_req = 1'b0;
    step(1);
    chk("R9", "cke back high", int'(cke), 1);
    chk("R9", "hold at exit", int'(cmd_hold), 1);
    chk("R10", "no request at exit", int'(req_valid), 0);
    step(TR);
    chk("R9", "hold at end of wait", int'(cmd_hold), 1);
    step(1);
    chk("R9", "hold released", int'(cmd_hold), 0);

    step(RI - 1);
    chk("R2", "backlog before restart interval", int'(backlog), 0);
    step(1);
    chk("R2", "backlog after restart interval", int'(backlog), 1);
    step(1);
    chk("R3", "auto request after exit", int'(req_valid), 1);
    chk("R3", "auto kind after exit", int'(req_kind), 0);
    step(RI);
    chk("R4", "still pending", int'(req_valid), 1);
    chk("R4", "kind stable", int'(req_kind), 0);
    chk("R2", "second interval counted", int'(backlog), 2);

    exp_q.push_back(1'b0);
    req_ready = 1'b1;
    step(1);
    chk("R3", "backlog after transfer", int'(backlog), 1);
    chk("R7", "valid low at grant", int'(req_valid), 0);
    for (int i = 0; i < TR; i++) begin
      step(1);
      chk("R7", "valid low in gap", int'(req_valid), 0);
    end
    step(1);
    req_ready = 1'b0;
    chk("R7", "valid after gap", int'(req_valid), 1);
    step(2);
    chk("R3", "expected transfers consumed", exp_q.size(), 0);

    finish_run();
  end
endmodule